// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Receiver

This block is the digital front end of a two-channel 12-bit converter. A host sends 16-bit command words over a three-wire link made of a serial clock, a data line and an active-low select. The block runs on a local system clock. It brings the three link signals across with synchronizers and finds the rising edges of the serial clock. It frames each word and decodes the word into a data update for one channel, a shutdown request or a rejected frame.

Each word has four control bits followed by a 12-bit twos-complement code, and the most significant bit is sent first. Bit 15 picks the channel: 0 selects A and 1 selects B. Bit 14 is ignored. Bit 13 requests shutdown. Bit 12 is reserved and must be 0. A word takes effect on the 16th serial clock rise, and the select line does not have to rise first. The select line must go high before the block accepts another word.

The receiver is a three-state machine:
- RX_DONE is the reset state and is also entered after each completed word. When select is high it moves to RX_IDLE (the "rearm" transition).
- RX_IDLE moves to RX_SHIFT when select goes low (the "start" transition).
- RX_SHIFT returns to RX_IDLE if select rises early (the "abort" transition). It moves to RX_DONE on the 16th rise (the "commit" transition).

Top module: `dacrx_top`

## Requirements
- R1: After reset both codes are 0, `shutdown` is 0, `frame_err` is 0 and no update strobe is asserted.
- R2: A completed word whose bit 12 and bit 13 are both 0 loads bits 11..0 into the channel selected by bit 15 (0 = A, 1 = B). The matching strobe pulses for one system clock, and the other channel does not change.
- R3: The word takes effect after its 16th serial clock rise while select is still low.
- R4: After the 16th rise, further serial clock rises with select held low change nothing. A new word is accepted only after select has gone high and then low again.
- R5: If select rises after fewer than 16 rises, the partial word is dropped. No output changes, and the next full word is received correctly.
- R6: A completed word with bit 12 = 1 sets `frame_err` and changes neither code nor `shutdown`, and no strobe pulses. The next completed word with bit 12 = 0 clears `frame_err`.
- R7: A completed word with bit 13 = 1 (and bit 12 = 0) sets `shutdown` and records bit 15. It does not change either code and pulses no strobe.
- R8: While `shutdown` is 1, a word with bit 13 = 0 still updates its channel. It clears `shutdown` only when its bit 15 equals the recorded bit.
- R9: Bit 14 has no effect on any output.
- R10: Serial clock rises while select is high place no bits in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data, sampled on the sclk rise |
| cs_n | input | 1 | Active-low frame select |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| upd_a | output | 1 | One-cycle strobe when code_a is loaded |
| upd_b | output | 1 | One-cycle strobe when code_b is loaded |
| shutdown | output | 1 | Both channels and the bias output are in high impedance |
| frame_err | output | 1 | The last completed word had the reserved bit set |

## Verification
The assertions assume that the serial link is much slower than the system clock. Each serial clock level, and each select change, must last several system clocks after synchronization. Data must be stable around each serial clock rise, and select must not change in the same cycle as a rise. The bench keeps to these limits. Each serial clock half period lasts five system clocks, and data changes only while the serial clock is low. Select changes at least five system clocks away from any rise.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
    // Control bits above the data code: address, ignored, shutdown, reserved
    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        RX_DONE  = 2'd0,
        RX_IDLE  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame
    import dacrx_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic               csn_s,
    output logic               commit,
    output logic [FRAME_W-1:0] word
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    rx_state_e        st, st_nx;
    logic             sclk_q;
    logic             rise;
    logic             last;
    logic [CNT_W-1:0] cnt;

    assign rise = sclk_s & ~sclk_q;
    assign last = (cnt == CNT_W'(FRAME_W - 1));

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_DONE:  if (csn_s) st_nx = RX_IDLE;          // rearm
            RX_IDLE:  if (!csn_s) st_nx = RX_SHIFT;        // start
            RX_SHIFT: begin
                if (csn_s)             st_nx = RX_IDLE;    // abort
                else if (rise && last) st_nx = RX_DONE;    // commit
            end
            default:  st_nx = RX_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_DONE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cnt    <= '0;
            word   <= '0;
            commit <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            commit <= 1'b0;
            if (st == RX_IDLE) begin
                cnt <= '0;
            end else if (st == RX_SHIFT && !csn_s && rise) begin
                word   <= {word[FRAME_W-2:0], sdi_s};
                cnt    <= cnt + 1'b1;
                commit <= last;
            end
        end
    end

    // R4
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RX_SHIFT) |=> !commit);
    // R5
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_SHIFT && csn_s) |=> (st == RX_IDLE && !commit));
    // R3
    commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (st == RX_DONE));
endmodule

// File: rtl/dacrx_regs.sv
module dacrx_regs #(
    parameter int DATA_W = 12,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] word,
    output logic [DATA_W-1:0]  code_a,
    output logic [DATA_W-1:0]  code_b,
    output logic               upd_a,
    output logic               upd_b,
    output logic               shutdown,
    output logic               frame_err
);
    localparam int ADDR_BIT = FRAME_W - 1;
    localparam int DC_BIT   = FRAME_W - 2;
    localparam int SD_BIT   = FRAME_W - 3;
    localparam int RSV_BIT  = FRAME_W - 4;

    logic sd_addr;
    logic unused_dc;
    assign unused_dc = word[DC_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_a    <= '0;
            code_b    <= '0;
            upd_a     <= 1'b0;
            upd_b     <= 1'b0;
            shutdown  <= 1'b0;
            sd_addr   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            upd_a <= 1'b0;
            upd_b <= 1'b0;
            if (commit) begin
                frame_err <= word[RSV_BIT];
                if (!word[RSV_BIT]) begin
                    if (word[SD_BIT]) begin
                        shutdown <= 1'b1;
                        sd_addr  <= word[ADDR_BIT];
                    end else begin
                        if (word[ADDR_BIT]) begin
                            code_b <= word[DATA_W-1:0];
                            upd_b  <= 1'b1;
                        end else begin
                            code_a <= word[DATA_W-1:0];
                            upd_a  <= 1'b1;
                        end
                        if (word[ADDR_BIT] == sd_addr) shutdown <= 1'b0;
                    end
                end
            end
        end
    end

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_a, upd_b}));
    // R2
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_a |-> $stable(code_a));
    // R2
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_b |-> $stable(code_b));
    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!upd_a && !upd_b));
    // R7
    sd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown) |-> (!upd_a && !upd_b));
    // R8
    sd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> (upd_a || upd_b));
endmodule

// File: rtl/dacrx_top.sv
module dacrx_top #(
    parameter int DATA_W = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              upd_a,
    output logic              upd_b,
    output logic              shutdown,
    output logic              frame_err
);
    localparam int FRAME_W = DATA_W + dacrx_pkg::CTRL_BITS;

    logic [2:0]         synced;
    logic               commit;
    logic [FRAME_W-1:0] word;

    dacrx_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sdi, sclk}),
        .q     (synced)
    );

    dacrx_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (synced[0]),
        .sdi_s  (synced[1]),
        .csn_s  (synced[2]),
        .commit (commit),
        .word   (word)
    );

    dacrx_regs #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .word      (word),
        .code_a    (code_a),
        .code_b    (code_b),
        .upd_a     (upd_a),
        .upd_b     (upd_b),
        .shutdown  (shutdown),
        .frame_err (frame_err)
    );
endmodule

// File: tb/tb_dacrx_top.sv
module tb_dacrx_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cs_n = 1'b1;
    logic [11:0] code_a, code_b;
    logic upd_a, upd_b, shutdown, frame_err;
    int errors = 0;
    int checks = 0;
    int n_a = 0;
    int n_b = 0;

    always #5 clk = ~clk;

    dacrx_top dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .code_a(code_a), .code_b(code_b), .upd_a(upd_a), .upd_b(upd_b),
        .shutdown(shutdown), .frame_err(frame_err)
    );

    always @(posedge clk) begin
        if (upd_a) n_a <= n_a + 1;
        if (upd_b) n_b <= n_b + 1;
    end

    function automatic logic [15:0] mk(input logic addr, input logic dc,
                                       input logic sd, input logic rsv,
                                       input logic [11:0] d);
        return {addr, dc, sd, rsv, d};
    endfunction

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[15 - i];
            wait_clk(5);
            sclk = 1'b1;
            wait_clk(5);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [15:0] w);
        cs_n = 1'b0;
        wait_clk(6);
        shift_bits(w, 16);
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic zero_counts();
        wait_clk(2);
        n_a = 0;
        n_b = 0;
    endtask

    task automatic t_reset();
        chk("R1", "code_a", code_a, 0);
        chk("R1", "code_b", code_b, 0);
        chk("R1", "shutdown", shutdown, 0);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "strobes", n_a + n_b, 0);
    endtask

    task automatic t_write();
        zero_counts();
        send(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h7FF));
        chk("R2", "code_a", code_a, 12'h7FF);
        chk("R2", "code_b untouched", code_b, 0);
        chk("R2", "upd_a pulses", n_a, 1);
        chk("R2", "upd_b pulses", n_b, 0);
        // R9: ignored bit set
        send(mk(1'b1, 1'b1, 1'b0, 1'b0, 12'h800));
        chk("R9", "code_b", code_b, 12'h800);
        chk("R9", "frame_err", frame_err, 0);
        chk("R9", "shutdown", shutdown, 0);
        chk("R2", "upd_b pulses", n_b, 1);
        chk("R2", "code_a kept", code_a, 12'h7FF);
    endtask

    task automatic t_no_raise();
        zero_counts();
        cs_n = 1'b0;
        wait_clk(6);
        shift_bits(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h123), 16);
        wait_clk(10);
        chk("R3", "code_a before select rise", code_a, 12'h123);
        chk("R3", "upd_a pulses", n_a, 1);
        shift_bits(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h456), 16);
        wait_clk(10);
        chk("R4", "code_a after extra edges", code_a, 12'h123);
        chk("R4", "upd_a pulses", n_a, 1);
        cs_n = 1'b1;
        wait_clk(10);
        send(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h456));
        chk("R4", "code_a after rearm", code_a, 12'h456);
    endtask

    task automatic t_abort();
        zero_counts();
        cs_n = 1'b0;
        wait_clk(6);
        shift_bits(mk(1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF), 10);
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(10);
        chk("R5", "code_b after partial", code_b, 12'h800);
        chk("R5", "strobes", n_a + n_b, 0);
        send(mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h0A5));
        chk("R5", "code_b after recovery", code_b, 12'h0A5);
    endtask

    task automatic t_reserved();
        zero_counts();
        send(mk(1'b0, 1'b0, 1'b0, 1'b1, 12'hABC));
        chk("R6", "frame_err", frame_err, 1);
        chk("R6", "code_a kept", code_a, 12'h456);
        chk("R6", "strobes", n_a + n_b, 0);
        send(mk(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC));
        chk("R6", "shutdown kept", shutdown, 0);
        send(mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h111));
        chk("R6", "frame_err cleared", frame_err, 0);
    endtask

    task automatic t_shutdown();
        zero_counts();
        send(mk(1'b1, 1'b0, 1'b1, 1'b0, 12'h555));
        chk("R7", "shutdown", shutdown, 1);
        chk("R7", "code_b kept", code_b, 12'h111);
        chk("R7", "code_a kept", code_a, 12'h456);
        chk("R7", "strobes", n_a + n_b, 0);
        send(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h321));
        chk("R8", "code_a on mismatch", code_a, 12'h321);
        chk("R8", "shutdown on mismatch", shutdown, 1);
        send(mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h654));
        chk("R8", "code_b on match", code_b, 12'h654);
        chk("R8", "shutdown on match", shutdown, 0);
    endtask

    task automatic t_idle_edges();
        zero_counts();
        sdi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_clk(5);
            sclk = 1'b1;
            wait_clk(5);
            sclk = 1'b0;
        end
        wait_clk(5);
        chk("R10", "strobes while select high", n_a + n_b, 0);
        send(mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h00F));
        chk("R10", "code_a after idle edges", code_a, 12'h00F);
        chk("R10", "code_b kept", code_b, 12'h654);
    endtask

    initial begin
        fork
            begin
                wait_clk(4);
                rst_n = 1'b1;
                wait_clk(4);
                t_reset();
                t_write();
                t_no_raise();
                t_abort();
                t_reserved();
                t_shutdown();
                t_idle_edges();
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule